// File: doc/BRIEF.md
# Two-Wire Byte Memory Slave with Supply Lockout

This block is a two-wire bus slave in front of a byte-wide memory. It oversamples the bus clock and data lines with the system clock. It recognises START and STOP conditions and matches a 7-bit device address. It then takes two address bytes that together load a 15-bit pointer. After that it either stores incoming data bytes at successive pointer values or returns bytes from the pointer to the master.

A supply-fail input comes from an external comparator. It forces the slave off the bus and blocks all writes. It also raises a reset output. When the input drops again, the lockout and the reset stay in force for a programmable number of system clock cycles. Only then does the slave answer the bus again. Memory contents are kept throughout. The pointer is always 15 bits wide. The memory array decodes only its low `MEM_AW` bits, so higher pointer values alias onto it.

Top module: `sram2w_slave`

## Requirements
- R1: The slave pulls SDA low during the ninth clock (acknowledge) after an address byte that matches `DEV_ADDR` in bits 7..1. It does the same after each of the two pointer bytes and after every data byte of a write.
- R2: The first pointer byte supplies pointer bits 14..8 from its bits 6..0, and its bit 7 has no effect. The second pointer byte supplies bits 7..0. The memory uses pointer bits `MEM_AW-1`..0.
- R3: Each data byte of a write is stored at the pointer, and the pointer then advances by one. The pointer steps from 0x7FFF to 0x0000.
- R4: An address byte whose bits 7..1 differ from `DEV_ADDR` is not acknowledged. No later byte is acknowledged until the next START.
- R5: An address byte with bit 0 = 1 starts a read. The slave shifts out the byte at the pointer, MSB first, and advances the pointer each time the master acknowledges. A master non-acknowledge ends the read.
- R6: `rst_out` is high in every cycle in which `pfail_i` is high, with no clock delay.
- R7: After `pfail_i` falls, `rst_out` stays high for `REC_CYCLES` rising clock edges and then goes low. A new high on `pfail_i` during that window starts the count again.
- R8: While `rst_out` is high, `sda_oe` is low, no byte is acknowledged and nothing is written. Bytes stored earlier read back unchanged afterwards.
- R9: A STOP ends any transaction, and bytes clocked after it with no START are not acknowledged. A repeated START begins a new address phase at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| pfail_i | input | 1 | High while the supply is below the fail threshold |
| sda_oe | output | 1 | When high, the data line is pulled low (open drain) |
| rst_out | output | 1 | Reset output, high during a supply fail and the recovery window |

## Verification
The hardest case to reach is a supply fail that lands in the middle of a write. It has to arrive after the pointer is loaded and a byte is stored, but while the master is still clocking the next byte. That byte must then be lost, and the byte that was already stored must survive. The bench raises the supply-fail input between two data bytes of a live write. It clocks another byte into the lockout. It then tries a full address phase while the recovery window is still running. It also re-pulses the fail input inside that window. Last, it reads the neighbouring locations back once the window has closed.

// File: rtl/sram2w_slave.sv
module sram2w_slave #(
  parameter logic [6:0] DEV_ADDR   = 7'h50,
  parameter int         PTR_W      = 15,
  parameter int         MEM_AW     = 10,
  parameter int         REC_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic pfail_i,
  output logic sda_oe,
  output logic rst_out
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int HW    = PTR_W - 8;
  localparam int RW    = $clog2(REC_CYCLES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DACK, S_A0, S_A0ACK, S_A1, S_A1ACK, S_WR, S_WACK, S_RD, S_RACK
  } st_t;

  st_t              st;
  logic [2:0]       scl_s, sda_s;
  logic [3:0]       cnt;
  logic [7:0]       sh;
  logic [HW-1:0]    a_hi;
  logic [PTR_W-1:0] ptr;
  logic             oe_q, rnw;
  logic [RW-1:0]    rec;
  logic [7:0]       mem [DEPTH];

  wire scl_rise = scl_s[1] & ~scl_s[2];
  wire scl_fall = ~scl_s[1] & scl_s[2];
  wire start_c  = scl_s[1] & scl_s[2] & sda_s[2] & ~sda_s[1];
  wire stop_c   = scl_s[1] & scl_s[2] & ~sda_s[2] & sda_s[1];
  wire sda_b    = sda_s[1];
  wire [7:0] rd_byte = mem[ptr[MEM_AW-1:0]];
  wire we = !rst_out && !start_c && !stop_c && scl_fall && st == S_WR && cnt == 4'd8;

  assign rst_out = pfail_i | (rec != '0);
  assign sda_oe  = oe_q & ~rst_out;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rec <= '0;
    else if (pfail_i) rec <= RW'(REC_CYCLES);
    else if (rec != '0) rec <= rec - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= 3'b111;
      sda_s <= 3'b111;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end

  always_ff @(posedge clk)
    if (we) mem[ptr[MEM_AW-1:0]] <= sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; a_hi <= '0; ptr <= '0; oe_q <= 1'b0; rnw <= 1'b0;
    end else if (rst_out) begin
      st <= S_IDLE; cnt <= '0; oe_q <= 1'b0;
    end else if (start_c) begin
      st <= S_DEV; cnt <= '0; oe_q <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; oe_q <= 1'b0;
    end else begin
      if (scl_rise)
        case (st)
          S_DEV, S_A0, S_A1, S_WR: begin
            sh  <= {sh[6:0], sda_b};
            cnt <= cnt + 4'd1;
          end
          S_RACK:
            if (sda_b) st <= S_IDLE;
            else ptr <= ptr + 1'b1;
          default: ;
        endcase
      if (scl_fall)
        case (st)
          S_DEV:
            if (cnt == 4'd8) begin
              if (sh[7:1] == DEV_ADDR) begin
                st <= S_DACK; oe_q <= 1'b1; rnw <= sh[0];
              end else st <= S_IDLE;
            end
          S_A0:
            if (cnt == 4'd8) begin
              a_hi <= sh[HW-1:0]; st <= S_A0ACK; oe_q <= 1'b1;
            end
          S_A1:
            if (cnt == 4'd8) begin
              ptr <= {a_hi, sh}; st <= S_A1ACK; oe_q <= 1'b1;
            end
          S_WR:
            if (cnt == 4'd8) begin
              ptr <= ptr + 1'b1; st <= S_WACK; oe_q <= 1'b1;
            end
          S_DACK: begin
            cnt <= '0;
            if (rnw) begin
              st <= S_RD; sh <= rd_byte; oe_q <= ~rd_byte[7];
            end else begin
              st <= S_A0; oe_q <= 1'b0;
            end
          end
          S_A0ACK: begin st <= S_A1; cnt <= '0; oe_q <= 1'b0; end
          S_A1ACK, S_WACK: begin st <= S_WR; cnt <= '0; oe_q <= 1'b0; end
          S_RD:
            if (cnt == 4'd7) begin
              st <= S_RACK; oe_q <= 1'b0;
            end else begin
              sh <= {sh[6:0], 1'b0}; oe_q <= ~sh[6]; cnt <= cnt + 4'd1;
            end
          S_RACK: begin
            st <= S_RD; sh <= rd_byte; oe_q <= ~rd_byte[7]; cnt <= '0;
          end
          default: ;
        endcase
    end

  // R1
  oe_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st == S_DACK || st == S_A0ACK || st == S_A1ACK || st == S_WACK || st == S_RD));

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ptr == PTR_W'($past(ptr) + 1'b1));

  // R5
  rd_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RACK && scl_rise && !sda_b && !rst_out && !start_c && !stop_c)
      |=> ptr == PTR_W'($past(ptr) + 1'b1));

  // R7
  rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pfail_i) |-> rst_out);

  // R8
  lock_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out |=> (st == S_IDLE && !oe_q));
endmodule

// File: tb/sram2w_slave_tb.sv
module sram2w_slave_tb_top;
  localparam int REC = 300;
  localparam int Q   = 4;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, pfail = 1'b0;
  logic sda_oe, rst_out;
  wire  sda_line = sda_m & ~sda_oe;

  int compared = 0, mismatched = 0, mrec = 0;
  bit done = 1'b0;
  byte unsigned mm [int];

  sram2w_slave #(.DEV_ADDR(7'h50), .PTR_W(15), .MEM_AW(10), .REC_CYCLES(REC)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .pfail_i(pfail),
    .sda_oe(sda_oe), .rst_out(rst_out));

  always #4 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-clock reference of the lockout (R6, R7, R8)
  always @(posedge clk) begin
    if (!rst_n) mrec = 0;
    else if (pfail) mrec = REC;
    else if (mrec > 0) mrec--;
    #3;
    if (rst_n) begin
      chk("R6/R7 rst_out", int'(rst_out), int'(pfail || mrec > 0));
      if (pfail || mrec > 0) chk("R8 sda_oe during lock", int'(sda_oe), 0);
    end
  end

  task automatic wq(int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic b_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic b_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(bit b);
    sda_m = b; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq();
  endtask

  task automatic recv_bit(output bit b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(byte unsigned v, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(s);
    ack = !s;
  endtask

  task automatic recv_byte(bit give_ack, output byte unsigned v);
    bit s;
    for (int i = 7; i >= 0; i--) begin recv_bit(s); v[i] = s; end
    send_bit(!give_ack);
  endtask

  task automatic set_ptr(int a0, int a1, string req);
    bit ack;
    b_start();
    send_byte(8'hA0, ack); chk({req, " dev ack"}, int'(ack), 1);
    send_byte(byte'(a0), ack); chk({req, " A0 ack"}, int'(ack), 1);
    send_byte(byte'(a1), ack); chk({req, " A1 ack"}, int'(ack), 1);
  endtask

  task automatic wr_bytes(int a0, int a1, byte unsigned d[$]);
    bit ack;
    int p = ((a0 & 8'h7F) << 8) | a1;
    set_ptr(a0, a1, "R1 write");
    foreach (d[i]) begin
      send_byte(d[i], ack); chk("R1/R3 data ack", int'(ack), 1);
      mm[p & 1023] = d[i];
      p = (p + 1) & 16'h7FFF;
    end
    b_stop();
  endtask

  task automatic rd_check(int a0, int a1, int n, string req);
    bit ack;
    byte unsigned v;
    int p = ((a0 & 8'h7F) << 8) | a1;
    set_ptr(a0, a1, req);
    b_start(); // R9 repeated START
    send_byte(8'hA1, ack); chk({req, " R9 read dev ack"}, int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, v);
      chk({req, " R5 read data"}, int'(v), int'(mm[p & 1023]));
      p = (p + 1) & 16'h7FFF;
    end
    b_stop();
  endtask

  initial begin
    bit ack;
    repeat (5) @(negedge clk);
    chk("reset rst_out", int'(rst_out), 0);
    chk("reset sda_oe", int'(sda_oe), 0);
    rst_n = 1'b1;
    wq(2);

    // R1 R2: pointer byte with bit 7 set
    wr_bytes(8'h81, 8'h23, '{8'hDE, 8'hAD, 8'hBE, 8'hEF});
    // R2 R5: read back with bit 7 clear
    rd_check(8'h01, 8'h23, 4, "R2");

    // R4 mismatched device address
    b_start();
    send_byte(8'hA2, ack); chk("R4 wrong dev no ack", int'(ack), 0);
    send_byte(8'h00, ack); chk("R4 next byte no ack", int'(ack), 0);
    b_stop();

    // R3 wrap from 0x7FFF
    wr_bytes(8'h7F, 8'hFF, '{8'h11, 8'h22});
    rd_check(8'h7F, 8'hFF, 2, "R3 wrap");

    // R9 bytes after STOP without START
    set_ptr(8'h00, 8'h05, "R9");
    b_stop();
    scl_m = 1'b0; wq();
    send_byte(8'h55, ack); chk("R9 after stop no ack", int'(ack), 0);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(2);

    // R8 supply fail inside a write
    set_ptr(8'h01, 8'h22, "R8 pre");
    send_byte(8'h77, ack); chk("R8 data before fail ack", int'(ack), 1);
    mm[16'h0122 & 1023] = 8'h77;
    pfail = 1'b1; wq(2);
    send_byte(8'h99, ack); chk("R8 byte during fail no ack", int'(ack), 0);
    pfail = 1'b0; wq(5);
    b_start();
    send_byte(8'hA0, ack); chk("R8 dev during recovery no ack", int'(ack), 0);
    b_stop();
    // R7 restart of the recovery window
    pfail = 1'b1; wq(1); pfail = 1'b0;
    repeat (REC - 20) @(negedge clk);
    chk("R7 still locked", int'(rst_out), 1);
    repeat (25) @(negedge clk);
    chk("R7 released", int'(rst_out), 0);
    wq(2);
    rd_check(8'h01, 8'h22, 2, "R8 retained");

    wq(4);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule